// File: doc/BRIEF.md
# Indirect 64-bit Register Access Bridge

This block gives a host with a 32-bit register port a way into a 64-bit register space that it cannot address directly. The host stages a 64-bit value in two 32-bit data words (upper half and lower half), then writes a command word. Bit 31 of the command word chooses a store (set) or a fetch (clear); bits 30:0 give a register index. The bridge adds a fixed window base of 0x70000 and a per-instance base to that index, and performs one 64-bit access on an internal request/acknowledge bus. After a fetch the returned value sits in the two data words, upper half at 0x00 and lower half at 0x04.

A status word reports progress and trouble: bit 0 (busy) is high while an access is outstanding, and bit 31 (error) is a sticky summary flag. The error flag is raised by a rejected address, a command issued while busy, an error response, or an access left unanswered for `TIMEOUT` cycles. Any write to the clear register at 0x18 drops it. An enable bit at 0x20 (bit 0) lets each completed access pulse an interrupt line.

The control is a two-state machine. `ST_IDLE` waits for a command. The transition *accept* (a command write whose computed address is legal) latches address, write flag and data and moves to `ST_WAIT`. `ST_WAIT` drives the internal request. The transition *finish* (acknowledge, error response or timeout) returns it to `ST_IDLE`. A command with an illegal address is *rejected* in `ST_IDLE` and the machine stays there. A command that arrives in `ST_WAIT` is a *collision*: the machine stays in `ST_WAIT`.

Top module: `ibr_bridge`

## Requirements
- R1: After reset the status word, both data words, the command word and the interrupt enable read 0, and `bus_req` and `irq` are low.
- R2: A host write to 0x08 with bit 31 set, made in `ST_IDLE` with a legal address, starts a store. `bus_req` is high from the next cycle, with `bus_write`=1 and `bus_wdata` = {word at 0x00, word at 0x04}.
- R3: A command with bit 31 clear starts a fetch. On its acknowledge (without `bus_err`), `bus_rdata[63:32]` becomes readable at 0x00 and `bus_rdata[31:0]` at 0x04.
- R4: The target address is command[30:0] + 0x70000 + `UNIT_BASE`. If that sum has bit 31 set or overflows 32 bits, no access is made and status bit 31 is set.
- R5: Status bit 0 reads 1 from the cycle after an accepted command until the cycle after the access finishes, and reads 0 otherwise.
- R6: A command written while busy sets status bit 31 and is otherwise ignored: no second access is made and the outstanding address, direction and data are unchanged.
- R7: An `bus_err` response ends the access, sets status bit 31 and leaves both data words unchanged.
- R8: If an access gets no response, `bus_req` stays high for exactly `TIMEOUT` cycles, then drops and status bit 31 is set.
- R9: Status bit 31 stays set, even across later good accesses, until any host write to 0x18. That write clears it unless a new error event happens in the same cycle.
- R10: When bit 0 of the register at 0x20 is 1, `irq` is high for exactly one cycle, the cycle after any access finishes (acknowledge, error or timeout). When that bit is 0, or the command is rejected, `irq` stays low.
- R11: Every host read gives `hst_rvalid` high one cycle later with the register value. 0x08 returns the last accepted command word, 0x18 and unmapped offsets return 0, and writes to unmapped offsets have no effect.
- R12: While `bus_req` is high and no response or timeout has ended the access, `bus_req`, `bus_write`, `bus_addr` and `bus_wdata` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_valid | input | 1 | Host request valid |
| hst_write | input | 1 | Host request is a write |
| hst_addr | input | HOST_AW | Host byte offset |
| hst_wdata | input | 32 | Host write data |
| hst_ready | output | 1 | Request accepted (always 1: every request takes one cycle) |
| hst_rvalid | output | 1 | Read data valid, one cycle after a read request |
| hst_rdata | output | 32 | Read data |
| bus_req | output | 1 | Internal access request, held until response or timeout |
| bus_write | output | 1 | Internal access is a store |
| bus_addr | output | 32 | Internal target address |
| bus_wdata | output | 64 | Internal store data |
| bus_rdata | input | 64 | Internal fetch data, valid with `bus_ack` |
| bus_ack | input | 1 | Access completed successfully |
| bus_err | input | 1 | Access completed with an error |
| irq | output | 1 | One-cycle completion pulse when enabled |

## Verification
A command accepted at clock edge k raises `bus_req` after that edge. A response seen at edge k+d loads the data words and clears busy after that edge, and `irq` is high for the cycle after edge k+d. A host read launched before an edge returns its data after that same edge. The bench drives every input half a cycle before an edge and samples every output half a cycle after it. Its target model answers at a chosen count of request cycles, so each expected value is known for one exact sampling point. The timeout check counts `bus_req` cycles at each falling edge and expects exactly 1024.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } ibr_state_e;

    localparam logic [7:0] OFS_DHI  = 8'h00;
    localparam logic [7:0] OFS_DLO  = 8'h04;
    localparam logic [7:0] OFS_CMD  = 8'h08;
    localparam logic [7:0] OFS_CLR  = 8'h18;
    localparam logic [7:0] OFS_STAT = 8'h1C;
    localparam logic [7:0] OFS_IEN  = 8'h20;

    localparam int CMD_WR_BIT    = 31;
    localparam int STAT_ERR_BIT  = 31;
    localparam int STAT_BUSY_BIT = 0;
endpackage

// File: rtl/ibr_addr_calc.sv
module ibr_addr_calc #(
    parameter int          AW         = 32,
    parameter logic [31:0] FIXED_BASE = 32'h0007_0000,
    parameter logic [31:0] UNIT_BASE  = 32'h0000_0000
) (
    input  logic [AW-2:0] idx,
    output logic [AW-1:0] addr,
    output logic          bad
);
    logic [AW:0] sum;

    always_comb begin
        sum  = {2'b00, idx} + {1'b0, FIXED_BASE[AW-1:0]} + {1'b0, UNIT_BASE[AW-1:0]};
        addr = sum[AW-1:0];
        // R4: reject a sum with the top address bit set or a carry out
        bad  = sum[AW] | sum[AW-1];
    end
endmodule

// File: rtl/ibr_watchdog.sv
module ibr_watchdog #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (!expire)   cnt <= cnt + 1'b1;
    end

    assign expire = run && (cnt == CW'(LIMIT - 1));

    assert_expire_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !run);
endmodule

// File: rtl/ibr_bridge.sv
module ibr_bridge
    import ibr_pkg::*;
#(
    parameter int          HOST_AW    = 8,
    parameter int          TIMEOUT    = 1024,
    parameter logic [31:0] FIXED_BASE = 32'h0007_0000,
    parameter logic [31:0] UNIT_BASE  = 32'h0000_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hst_valid,
    input  logic               hst_write,
    input  logic [HOST_AW-1:0] hst_addr,
    input  logic [31:0]        hst_wdata,
    output logic               hst_ready,
    output logic               hst_rvalid,
    output logic [31:0]        hst_rdata,
    output logic               bus_req,
    output logic               bus_write,
    output logic [31:0]        bus_addr,
    output logic [63:0]        bus_wdata,
    input  logic [63:0]        bus_rdata,
    input  logic               bus_ack,
    input  logic               bus_err,
    output logic               irq
);
    localparam int AW = 32;

    ibr_state_e state, state_nx;

    logic [31:0]   dhi_q, dlo_q, cmd_q;
    logic          ien_q, err_q, irq_q;
    logic          wr_q;
    logic [AW-1:0] addr_q;
    logic [63:0]   wdata_q;
    logic [AW-1:0] calc_addr;
    logic          calc_bad, expire;

    logic wr_any, rd_any, wr_cmd, accept, finish, err_set, clr_hit;

    ibr_addr_calc #(.AW(AW), .FIXED_BASE(FIXED_BASE), .UNIT_BASE(UNIT_BASE)) u_calc (
        .idx  (hst_wdata[AW-2:0]),
        .addr (calc_addr),
        .bad  (calc_bad)
    );

    ibr_watchdog #(.LIMIT(TIMEOUT)) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == ST_WAIT),
        .expire (expire)
    );

    always_comb begin
        wr_any  = hst_valid && hst_write;
        rd_any  = hst_valid && !hst_write;
        wr_cmd  = wr_any && (hst_addr == HOST_AW'(OFS_CMD));
        clr_hit = wr_any && (hst_addr == HOST_AW'(OFS_CLR));
        accept  = (state == ST_IDLE) && wr_cmd && !calc_bad;
        finish  = (state == ST_WAIT) && (bus_ack || bus_err || expire);
        err_set = (wr_cmd && ((state == ST_WAIT) || calc_bad))
               || ((state == ST_WAIT) && (bus_err || expire));
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept) state_nx = ST_WAIT;
            ST_WAIT: if (finish) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath and host registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dhi_q      <= '0;
            dlo_q      <= '0;
            cmd_q      <= '0;
            ien_q      <= 1'b0;
            err_q      <= 1'b0;
            irq_q      <= 1'b0;
            wr_q       <= 1'b0;
            addr_q     <= '0;
            wdata_q    <= '0;
            hst_rvalid <= 1'b0;
            hst_rdata  <= '0;
        end else begin
            if (wr_any && hst_addr == HOST_AW'(OFS_DHI)) dhi_q <= hst_wdata;
            if (wr_any && hst_addr == HOST_AW'(OFS_DLO)) dlo_q <= hst_wdata;
            if (wr_any && hst_addr == HOST_AW'(OFS_IEN)) ien_q <= hst_wdata[0];
            if (finish && bus_ack && !bus_err && !wr_q) begin
                dhi_q <= bus_rdata[63:32];
                dlo_q <= bus_rdata[31:0];
            end
            if (accept) begin
                cmd_q   <= hst_wdata;
                wr_q    <= hst_wdata[CMD_WR_BIT];
                addr_q  <= calc_addr;
                wdata_q <= {dhi_q, dlo_q};
            end
            if (err_set)      err_q <= 1'b1;
            else if (clr_hit) err_q <= 1'b0;
            irq_q      <= finish && ien_q;
            hst_rvalid <= rd_any;
            if (rd_any) begin
                unique case (hst_addr)
                    HOST_AW'(OFS_DHI):  hst_rdata <= dhi_q;
                    HOST_AW'(OFS_DLO):  hst_rdata <= dlo_q;
                    HOST_AW'(OFS_CMD):  hst_rdata <= cmd_q;
                    HOST_AW'(OFS_STAT): hst_rdata <= {err_q, 30'd0, state == ST_WAIT};
                    HOST_AW'(OFS_IEN):  hst_rdata <= {31'd0, ien_q};
                    default:            hst_rdata <= '0;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        hst_ready = 1'b1;
        bus_req   = (state == ST_WAIT);
        bus_write = wr_q;
        bus_addr  = addr_q;
        bus_wdata = wdata_q;
        irq       = irq_q;
    end

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack && !bus_err && !expire)
        |=> (bus_req && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_write)));

    assert_addr_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !bus_addr[AW-1]);

    assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_irq_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(bus_req));

    assert_collision_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && wr_cmd && !bus_ack && !bus_err && !expire) |=> $stable(bus_addr));
endmodule

// File: tb/ibr_bridge_tb.sv
module ibr_bridge_tb;
    localparam logic [31:0] UB  = 32'h0000_0100;
    localparam logic [31:0] FB  = 32'h0007_0000;
    localparam int          TMO = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_valid = 1'b0, hst_write = 1'b0;
    logic [7:0]  hst_addr = '0;
    logic [31:0] hst_wdata = '0;
    logic        hst_ready, hst_rvalid;
    logic [31:0] hst_rdata;
    logic        bus_req, bus_write;
    logic [31:0] bus_addr;
    logic [63:0] bus_wdata;
    logic [63:0] bus_rdata = '0;
    logic        bus_ack = 1'b0, bus_err = 1'b0;
    logic        irq;

    always #4 clk = ~clk;

    ibr_bridge #(.TIMEOUT(TMO), .UNIT_BASE(UB)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .hst_valid(hst_valid), .hst_write(hst_write), .hst_addr(hst_addr),
        .hst_wdata(hst_wdata), .hst_ready(hst_ready), .hst_rvalid(hst_rvalid),
        .hst_rdata(hst_rdata), .bus_req(bus_req), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .bus_err(bus_err), .irq(irq)
    );

    int n_chk = 0, n_fail = 0;
    int tgt_delay = 1, tgt_cnt = 0, resp_cnt = 0, req_cycles = 0, irq_cnt = 0;
    bit tgt_err = 0, tgt_mute = 0;
    logic        tgt_wr;
    logic [31:0] tgt_addr;
    logic [63:0] tgt_wdata;

    function automatic logic [63:0] tdata(input logic [31:0] a);
        return {a ^ 32'hA5A5_0000, ~a};
    endfunction

    function automatic logic [31:0] exp_addr(input logic [30:0] idx);
        return {1'b0, idx} + FB + UB;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // target model: answers on the tgt_delay-th request cycle
    initial begin
        forever begin
            @(negedge clk);
            bus_ack = 1'b0;
            bus_err = 1'b0;
            if (irq) irq_cnt++;
            if (bus_req) begin
                req_cycles++;
                tgt_cnt++;
                if (!tgt_mute && tgt_cnt == tgt_delay) begin
                    if (tgt_err) bus_err = 1'b1;
                    else         bus_ack = 1'b1;
                    bus_rdata = tdata(bus_addr);
                    resp_cnt++;
                    tgt_wr    = bus_write;
                    tgt_addr  = bus_addr;
                    tgt_wdata = bus_wdata;
                end
            end else begin
                tgt_cnt = 0;
            end
        end
    end

    task automatic host_write(input logic [7:0] a, input logic [31:0] d);
        hst_valid = 1'b1; hst_write = 1'b1; hst_addr = a; hst_wdata = d;
        @(posedge clk);
        @(negedge clk);
        hst_valid = 1'b0; hst_write = 1'b0;
    endtask

    task automatic host_read(input logic [7:0] a, output logic [31:0] d);
        hst_valid = 1'b1; hst_write = 1'b0; hst_addr = a;
        @(posedge clk);
        @(negedge clk);
        hst_valid = 1'b0;
        d = hst_rdata;
        check(hst_rvalid === 1'b1, "R11 rvalid", {63'd0, hst_rvalid}, 64'd1);
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            host_read(8'h1C, s);
            if (s[0] == 1'b0) break;
        end
    endtask

    logic [31:0] rd, rd2;
    int r0, i0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(bus_req === 1'b0 && irq === 1'b0, "R1 bus_req/irq", {bus_req, irq}, 0);
        host_read(8'h1C, rd); check(rd == 0, "R1 status", rd, 0);
        host_read(8'h00, rd); check(rd == 0, "R1 data hi", rd, 0);
        host_read(8'h08, rd); check(rd == 0, "R1 command", rd, 0);
        host_read(8'h20, rd); check(rd == 0, "R1 irq enable", rd, 0);

        // R11 unmapped offset
        host_write(8'h10, 32'hDEAD_BEEF);
        host_read(8'h10, rd); check(rd == 0, "R11 unmapped", rd, 0);
        host_read(8'h1C, rd); check(rd == 0, "R11 unmapped write no effect", rd, 0);

        // R2 directed store
        tgt_delay = 3;
        host_write(8'h00, 32'h1122_3344);
        host_write(8'h04, 32'h5566_7788);
        host_write(8'h08, 32'h8000_0005);
        check(bus_req === 1'b1, "R2 req next cycle", {63'd0, bus_req}, 1);
        host_read(8'h1C, rd); check(rd == 32'h1, "R5 busy during access", rd, 1);
        wait_idle();
        check(tgt_wr === 1'b1, "R2 write flag", {63'd0, tgt_wr}, 1);
        check(tgt_wdata == 64'h1122_3344_5566_7788, "R2 wdata", tgt_wdata, 64'h1122_3344_5566_7788);
        check(tgt_addr == exp_addr(31'd5), "R4 address", tgt_addr, exp_addr(31'd5));
        host_read(8'h08, rd); check(rd == 32'h8000_0005, "R11 command readback", rd, 32'h8000_0005);
        host_read(8'h1C, rd); check(rd == 0, "R5 idle after", rd, 0);

        // R3 directed fetch
        tgt_delay = 2;
        host_write(8'h08, 32'h0000_0033);
        wait_idle();
        host_read(8'h00, rd);  check(rd == tdata(exp_addr(31'h33))[63:32], "R3 upper", rd, tdata(exp_addr(31'h33))[63:32]);
        host_read(8'h04, rd2); check(rd2 == tdata(exp_addr(31'h33))[31:0], "R3 lower", rd2, tdata(exp_addr(31'h33))[31:0]);

        // random mix
        void'($urandom(32'd1234));
        for (int it = 0; it < 30; it++) begin
            logic        wr, en;
            logic [30:0] idx;
            logic [31:0] hi, lo;
            wr = 1'($urandom); en = 1'($urandom);
            idx = 31'($urandom % 4096);
            hi = $urandom; lo = $urandom;
            tgt_delay = 1 + int'($urandom % 6);
            host_write(8'h20, {31'd0, en});
            host_write(8'h00, hi);
            host_write(8'h04, lo);
            r0 = resp_cnt; i0 = irq_cnt;
            host_write(8'h08, {wr, idx});
            wait_idle();
            @(negedge clk);
            check(resp_cnt == r0 + 1, "R2 one access", resp_cnt, r0 + 1);
            check(tgt_addr == exp_addr(idx), "R4 random address", tgt_addr, exp_addr(idx));
            check(irq_cnt == i0 + int'(en), "R10 irq pulse count", irq_cnt, i0 + int'(en));
            if (wr) begin
                check(tgt_wdata == {hi, lo}, "R2 random wdata", tgt_wdata, {hi, lo});
            end else begin
                host_read(8'h00, rd);
                host_read(8'h04, rd2);
                check({rd, rd2} == tdata(exp_addr(idx)), "R3 random fetch", {rd, rd2}, tdata(exp_addr(idx)));
            end
        end
        host_write(8'h20, 32'h0);

        // R4 boundary: largest legal index, then one above
        tgt_delay = 1;
        host_write(8'h08, 32'h7FF8_FEFF);
        wait_idle();
        check(tgt_addr == 32'h7FFF_FFFF, "R4 top legal address", tgt_addr, 32'h7FFF_FFFF);
        host_read(8'h1C, rd); check(rd == 0, "R4 legal no error", rd, 0);
        r0 = resp_cnt; i0 = irq_cnt;
        host_write(8'h20, 32'h1);
        host_write(8'h08, 32'h7FF8_FF00);
        check(bus_req === 1'b0, "R4 rejected no request", {63'd0, bus_req}, 0);
        host_read(8'h1C, rd); check(rd == 32'h8000_0000, "R4 rejected error", rd, 32'h8000_0000);
        check(resp_cnt == r0 && irq_cnt == i0, "R10 no irq on reject", irq_cnt, i0);
        host_read(8'h08, rd); check(rd == 32'h7FF8_FEFF, "R4 command kept", rd, 32'h7FF8_FEFF);
        host_write(8'h20, 32'h0);

        // R9 clear
        host_write(8'h18, 32'h0);
        host_read(8'h1C, rd); check(rd == 0, "R9 clear", rd, 0);

        // R6 collision
        tgt_delay = 30;
        r0 = resp_cnt;
        host_write(8'h08, 32'h0000_0007);
        host_write(8'h08, 32'h8000_0009);
        wait_idle();
        check(resp_cnt == r0 + 1, "R6 single access", resp_cnt, r0 + 1);
        check(tgt_addr == exp_addr(31'd7) && tgt_wr == 1'b0, "R6 first access kept", tgt_addr, exp_addr(31'd7));
        host_read(8'h1C, rd); check(rd == 32'h8000_0000, "R6 error set", rd, 32'h8000_0000);
        host_write(8'h18, 32'h1);

        // R7 error response, R9 sticky
        tgt_delay = 2; tgt_err = 1;
        host_read(8'h00, rd);
        host_write(8'h08, 32'h0000_0044);
        wait_idle();
        host_read(8'h1C, rd2); check(rd2 == 32'h8000_0000, "R7 error flag", rd2, 32'h8000_0000);
        host_read(8'h00, rd2); check(rd2 == rd, "R7 data unchanged", rd2, rd);
        tgt_err = 0;
        host_write(8'h08, 32'h0000_0045);
        wait_idle();
        host_read(8'h1C, rd); check(rd == 32'h8000_0000, "R9 sticky", rd, 32'h8000_0000);
        host_write(8'h18, 32'h0);
        host_read(8'h1C, rd); check(rd == 0, "R9 cleared", rd, 0);

        // R8 timeout
        tgt_mute = 1;
        host_write(8'h20, 32'h1);
        req_cycles = 0; i0 = irq_cnt;
        host_write(8'h08, 32'h0000_0050);
        wait_idle();
        @(negedge clk);
        check(req_cycles == TMO, "R8 request length", req_cycles, TMO);
        check(bus_req === 1'b0, "R8 request dropped", {63'd0, bus_req}, 0);
        host_read(8'h1C, rd); check(rd == 32'h8000_0000, "R8 error flag", rd, 32'h8000_0000);
        check(irq_cnt == i0 + 1, "R10 irq on timeout", irq_cnt, i0 + 1);
        tgt_mute = 0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule